// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped. It looks at the six destination-address bytes, which arrive one per cycle on a valid/ready byte stream, together with the frame length. It checks them against a configured minimum length, a promiscuous switch, a broadcast-disable switch, a multicast enable, a 48-bit station address and a 64-entry multicast hash table. One cycle after the sixth byte has been consumed, it reports the decision, whether the frame is group-addressed (broadcast or multicast), and a reason code.

The hash table is loaded by pulsing a clear strobe together with a byte count, then streaming multicast addresses one byte per cycle. A built-in CRC-32 engine hashes each completed address and sets the table bit that the address selects. A second CRC-32 engine of the same kind hashes each frame destination as its bytes arrive, so the table lookup costs no extra cycles. Storing the frame itself is left to the logic downstream.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: A frame whose length is below the effective minimum is rejected with reason 1. This check comes before every other check, and promiscuous mode does not bypass it.
- R2: The effective minimum is the configured minimum, raised to 5 when the configured value is below 5. A length of 4 is therefore always rejected.
- R3: When the length passes and promiscuous mode is on, the frame is accepted with reason 0 and the group flag low, whatever its destination.
- R4: A destination of all ones is broadcast. When broadcast-disable is set it is rejected with reason 2. Otherwise it is accepted with the group flag high.
- R5: Any other destination whose first received byte has bit 0 set is multicast. When the multicast enable is low it is rejected with reason 3.
- R6: With the multicast enable high, a multicast frame is accepted with the group flag high if its table bit is set. If the bit is clear, the frame is rejected with reason 4.
- R7: The table index is bits 7:2 of a CRC-32 over the six address bytes, taken in arrival order. The CRC uses the reflected polynomial 0xEDB88320, each byte least significant bit first, starts from all ones and is inverted at the end. Index i selects bit i&7 of table byte i>>3.
- R8: A clear strobe empties the table and records a byte count L. After that, the streamed address k (counting from 0) sets its bit only if (k+1)*6 <= L and k < 64. Bytes beyond L are ignored. Until the first clear, L is 0.
- R9: A unicast frame is accepted with the group flag low only if all six bytes equal the station address, whose bits 47:40 match the first received byte. Any other unicast frame is rejected with reason 5. Reason 0 always means accepted.
- R10: rx_ready is low for exactly the cycle after the sixth byte is consumed. dec_valid is high for one cycle, in the cycle after that.
- R11: After reset, dec_valid is low, rx_ready is high and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_promisc | input | 1 | Accept every frame of sufficient length |
| cfg_bcast_off | input | 1 | Reject broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames to reach the hash check |
| cfg_min_len | input | LEN_W | Configured minimum frame length |
| station_addr | input | 48 | Station address; bits 47:40 are the first byte |
| tbl_clear | input | 1 | Empty the hash table and latch tbl_len |
| tbl_len | input | TLEN_W | Byte count of the address list that follows |
| tbl_valid | input | 1 | tbl_byte carries a list byte this cycle |
| tbl_byte | input | 8 | Multicast list byte |
| rx_valid | input | 1 | rx_byte carries a destination byte |
| rx_ready | output | 1 | Filter can take a destination byte |
| rx_byte | input | 8 | Destination byte, first byte first |
| rx_len | input | LEN_W | Frame length, sampled with the first byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Accepted as broadcast or multicast |
| dec_reason | output | 3 | 0 ok, 1 short, 2 broadcast off, 3 multicast off, 4 hash miss, 5 unicast mismatch |

## Verification
The hardest outcomes to reach from the ports are that a listed address is not entered in the table because the byte count has cut it off or the 64-address cap has been hit. With arbitrary addresses, a later hit could simply land on a bit that an earlier address had already set. To rule that out, the stimulus repeats one address to fill every counted slot. It then places a second address, chosen by the bench's own CRC so that its index differs from the first, in the slot just past the limit, where a hit on that second address can only come from the slot that should have been ignored. The same search by index supplies a multicast address that is sure to miss. Mirror cases put that second address inside the limit, to show that it would have hit.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int LEN_W      = 11,
  parameter int TLEN_W     = 10,
  parameter int HASH_W     = 6,
  parameter int MAX_GROUPS = 64,
  parameter int MIN_FLOOR  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast_off,
  input  logic              cfg_mcast_en,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [47:0]       station_addr,
  input  logic              tbl_clear,
  input  logic [TLEN_W-1:0] tbl_len,
  input  logic              tbl_valid,
  input  logic [7:0]        tbl_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_group,
  output logic [2:0]        dec_reason
);
  localparam int TBL_N  = 1 << HASH_W;
  localparam int GCNT_W = $clog2(MAX_GROUPS + 1);
  localparam logic [31:0]       POLY    = 32'hEDB88320;
  localparam logic [31:0]       SEED    = 32'hFFFF_FFFF;
  localparam logic [LEN_W-1:0]  FLOOR_V = LEN_W'(MIN_FLOOR);
  localparam logic [GCNT_W-1:0] GMAX    = GCNT_W'(MAX_GROUPS);
  localparam logic [2:0] LAST_POS = 3'd5;
  localparam logic [2:0] RS_OK = 3'd0, RS_SHORT = 3'd1, RS_BCAST = 3'd2,
                         RS_MCOFF = 3'd3, RS_HASH = 3'd4, RS_UCAST = 3'd5;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (POLY & {32{r[0] ^ d[i]}});
    return r;
  endfunction

  // multicast table programming
  logic [TBL_N-1:0]  hash_tbl;
  logic [TLEN_W-1:0] tlen_q, tbcnt;
  logic [2:0]        tpos;
  logic [GCNT_W-1:0] gcnt;
  logic [31:0]       tcrc;

  wire t_take = tbl_valid && !tbl_clear && (tbcnt < tlen_q) && (gcnt < GMAX);
  wire [31:0] tcrc_nx = crc_step((tpos == 3'd0) ? SEED : tcrc, tbl_byte);
  wire [HASH_W-1:0] tidx = ~tcrc_nx[HASH_W+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hash_tbl <= '0;
      tlen_q   <= '0;
      tbcnt    <= '0;
      tpos     <= '0;
      gcnt     <= '0;
      tcrc     <= SEED;
    end else if (tbl_clear) begin
      hash_tbl <= '0;
      tlen_q   <= tbl_len;
      tbcnt    <= '0;
      tpos     <= '0;
      gcnt     <= '0;
    end else if (t_take) begin
      tbcnt <= tbcnt + 1'b1;
      tcrc  <= tcrc_nx;
      if (tpos == LAST_POS) begin
        tpos <= '0;
        gcnt <= gcnt + 1'b1;
        hash_tbl[tidx] <= 1'b1;
      end else begin
        tpos <= tpos + 1'b1;
      end
    end
  end

  // destination capture
  logic              deciding;
  logic [2:0]        fpos;
  logic [47:0]       dst_q;
  logic [LEN_W-1:0]  len_q;
  logic [31:0]       fcrc;

  assign rx_ready = !deciding;
  wire f_take = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deciding <= 1'b0;
      fpos     <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      fcrc     <= SEED;
    end else begin
      deciding <= f_take && (fpos == LAST_POS);
      if (f_take) begin
        fcrc  <= crc_step((fpos == 3'd0) ? SEED : fcrc, rx_byte);
        dst_q <= {dst_q[39:0], rx_byte};
        if (fpos == 3'd0) len_q <= rx_len;
        fpos  <= (fpos == LAST_POS) ? 3'd0 : fpos + 1'b1;
      end
    end
  end

  // decision
  wire [LEN_W-1:0]  eff_min = (cfg_min_len < FLOOR_V) ? FLOOR_V : cfg_min_len;
  wire              short_c = len_q < eff_min;
  wire              is_bc   = &dst_q;
  wire              is_mc   = dst_q[40];
  wire [HASH_W-1:0] fidx    = ~fcrc[HASH_W+1:2];

  logic       acc_c, grp_c;
  logic [2:0] rsn_c;

  always_comb begin
    acc_c = 1'b0;
    grp_c = 1'b0;
    rsn_c = RS_OK;
    if (short_c)                       rsn_c = RS_SHORT;
    else if (cfg_promisc)              acc_c = 1'b1;
    else if (is_bc) begin
      if (cfg_bcast_off)               rsn_c = RS_BCAST;
      else begin acc_c = 1'b1; grp_c = 1'b1; end
    end else if (is_mc) begin
      if (!cfg_mcast_en)               rsn_c = RS_MCOFF;
      else if (hash_tbl[fidx]) begin acc_c = 1'b1; grp_c = 1'b1; end
      else                             rsn_c = RS_HASH;
    end else if (dst_q == station_addr) acc_c = 1'b1;
    else                               rsn_c = RS_UCAST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_group  <= 1'b0;
      dec_reason <= RS_OK;
    end else begin
      dec_valid <= deciding;
      if (deciding) begin
        dec_accept <= acc_c;
        dec_group  <= grp_c;
        dec_reason <= rsn_c;
      end
    end
  end

  p_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (deciding && short_c) |=> (dec_valid && !dec_accept && dec_reason == RS_SHORT));
  p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (deciding && len_q < FLOOR_V) |=> !dec_accept);
  p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (deciding && !short_c && cfg_promisc) |=> (dec_accept && !dec_group));
  p_group_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_group) |-> dec_accept);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |=> (hash_tbl == '0));
  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gcnt == GMAX) |=> (gcnt == GMAX || $past(tbl_clear)));
  p_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (dec_reason == RS_OK)));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(!rx_ready));
endmodule

// File: tb/tb_eth_rx_addr_filter.sv
module tb_eth_rx_addr_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_promisc = 0, cfg_bcast_off = 0, cfg_mcast_en = 0;
  logic [10:0] cfg_min_len = 0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic tbl_clear = 0, tbl_valid = 0;
  logic [9:0] tbl_len = 0;
  logic [7:0] tbl_byte = 0, rx_byte = 0;
  logic rx_valid = 0, rx_ready;
  logic [10:0] rx_len = 0;
  logic dec_valid, dec_accept, dec_group;
  logic [2:0] dec_reason;

  always #10 clk = ~clk;

  eth_rx_addr_filter dut (.*);

  int checks = 0, errors = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  logic [63:0] m_tbl = '0;
  logic [47:0] gaddr[0:69];

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      c ^= {24'd0, a[47-8*b -: 8]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    return c[7:2];
  endfunction

  function automatic logic [4:0] model(input logic [47:0] d, input int len);
    int eff;
    eff = (cfg_min_len < 5) ? 5 : int'(cfg_min_len);
    if (len < eff)                return {2'b00, 3'd1};
    if (cfg_promisc)              return {2'b10, 3'd0};
    if (d == 48'hFFFF_FFFF_FFFF)  return cfg_bcast_off ? {2'b00, 3'd2} : {2'b11, 3'd0};
    if (d[40]) begin
      if (!cfg_mcast_en)          return {2'b00, 3'd3};
      return m_tbl[hidx(d)] ? {2'b11, 3'd0} : {2'b00, 3'd4};
    end
    return (d == station_addr) ? {2'b10, 3'd0} : {2'b00, 3'd5};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] d, input int len, input string tag);
    exp_q.push_back(model(d, len));
    tag_q.push_back(tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      while (!rx_ready) begin
        rx_valid = 0;
        @(negedge clk);
      end
      rx_valid = 1;
      rx_byte  = d[47-8*i -: 8];
      rx_len   = 11'(len);
    end
    @(negedge clk);
    rx_valid = 0;
    check(rx_ready == 0, "R10 ready low after sixth byte", rx_ready, 0);
    @(negedge clk);
  endtask

  task automatic prog(input int n, input int len);
    @(negedge clk);
    tbl_clear = 1;
    tbl_len = 10'(len);
    @(negedge clk);
    tbl_clear = 0;
    m_tbl = '0;
    for (int k = 0; k < n; k++) begin
      if ((k + 1) * 6 <= len && k < 64) m_tbl[hidx(gaddr[k])] = 1'b1;
      for (int b = 0; b < 6; b++) begin
        tbl_valid = 1;
        tbl_byte = gaddr[k][47-8*b -: 8];
        @(negedge clk);
      end
    end
    tbl_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      logic [4:0] e;
      string t;
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected decision", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({dec_accept, dec_group, dec_reason} == e, t,
              {dec_accept, dec_group, dec_reason}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] a, b, c, dd;
    a = 48'h01_00_5E_00_00_01;
    dd = 48'h01_00_5E_00_00_02;
    b = a;
    for (int i = 2; i < 256 && hidx(b) == hidx(a); i++) b = 48'h01_00_5E_00_01_00 + 48'(i);
    repeat (3) @(negedge clk);
    check(rx_ready == 1, "R11 ready after reset", rx_ready, 1);
    check(dec_valid == 0, "R11 no decision in reset", dec_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(rx_ready == 1 && dec_valid == 0, "R11 idle after reset", {rx_ready, dec_valid}, 2);

    cfg_mcast_en = 1;
    cfg_min_len = 60;
    send(a, 64, "R11 table empty after reset");
    send(station_addr, 64, "R9 unicast match");
    send(48'h02_11_22_33_44_54, 64, "R9 unicast last byte differs");
    send(48'h12_11_22_33_44_55, 64, "R9 unicast first byte differs");
    send(48'hFFFF_FFFF_FFFF, 64, "R4 broadcast accepted");
    cfg_bcast_off = 1;
    send(48'hFFFF_FFFF_FFFF, 64, "R4 broadcast disabled");
    cfg_bcast_off = 0;

    gaddr[0] = a;
    gaddr[1] = dd;
    prog(2, 12);
    c = a;
    for (int i = 3; i < 256 && m_tbl[hidx(c)]; i++) c = 48'h01_00_5E_00_02_00 + 48'(i);
    send(a, 64, "R6 R7 hash hit first");
    send(dd, 64, "R7 hash hit second");
    send(c, 64, "R6 hash miss");
    cfg_mcast_en = 0;
    send(a, 64, "R5 multicast disabled");
    cfg_mcast_en = 1;

    prog(0, 0);
    send(a, 64, "R8 clear empties table");

    gaddr[0] = a; gaddr[1] = a; gaddr[2] = b;
    prog(3, 17);
    send(b, 64, "R8 partial address ignored");
    send(a, 64, "R8 full address kept");
    prog(3, 18);
    send(b, 64, "R8 address inside count kept");

    for (int k = 0; k < 64; k++) gaddr[k] = a;
    gaddr[64] = b;
    prog(65, 390);
    send(b, 64, "R8 65th address ignored");
    gaddr[63] = b;
    prog(64, 384);
    send(b, 64, "R8 64th address kept");

    send(station_addr, 59, "R1 below minimum");
    send(station_addr, 60, "R1 at minimum");
    cfg_min_len = 0;
    send(station_addr, 4, "R2 floor rejects 4");
    send(station_addr, 5, "R2 floor accepts 5");
    cfg_min_len = 3;
    send(station_addr, 4, "R2 floor with small config");

    cfg_promisc = 1;
    cfg_bcast_off = 1;
    cfg_mcast_en = 0;
    cfg_min_len = 60;
    send(48'h0A_0B_0C_0D_0E_0F, 64, "R3 promiscuous unicast");
    send(48'hFFFF_FFFF_FFFF, 64, "R3 promiscuous broadcast");
    send(c, 64, "R3 promiscuous multicast");
    send(48'h0A_0B_0C_0D_0E_0F, 20, "R1 short in promiscuous");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all decisions seen", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule